// File: doc/BRIEF.md
# Saturating Event Counter with Storage Bank Steering

This block counts completed events and decides where the results of each event go when they are saved to non-volatile storage. An event is active while `event_i` is high. The event ends on the falling edge of `event_i`. At that point the counter advances by one and a commit strobe is raised. A bank index comes with the strobe. It names one of three banks that will receive the elapsed-time and event-count data. The bank is picked from the current count, so wear moves to the next bank as the count grows.

A second store holds the configuration, alarm and user words. The block keeps a shadow copy of these words. It requests a commit of that store only if a write changed a word during an active event, and only at the end of that event. The counter is visible as a low part and a separate MSB bit. It can be written through the register port. A power-up load port restores the counter and the shadow words without marking anything for commit.

Top module: `evt_bank_ctrl`

## Requirements
- R1: After reset, `count_lo_o`, `count_msb_o`, `commit_o`, `cfg_commit_o` and `bank_o` are all zero.
- R2: In the cycle after the clock edge that samples `event_i` low with the previous sample high, `commit_o` is 1 for exactly one cycle. In that same cycle the count already shows its old value plus one.
- R3: The count saturates at all ones (1FFFFh by default). Any further event end leaves it there but still raises `commit_o`.
- R4: `bank_o` is 0 while the count is below `BANK1_AT`, 1 from `BANK1_AT` up to `BANK2_AT`-1, and 2 at or above `BANK2_AT`. The value 3 never occurs.
- R5: A register write to address 0 sets the count's low bits from `wr_data_i`. A write to address 1 sets the MSB from `wr_data_i[0]`. A count cleared below `BANK1_AT` selects bank 0 again.
- R6: A write to a configuration word (address 2 and up) with `wr_in_event_i`=1 and data different from the held word makes `cfg_commit_o` pulse together with the next `commit_o`. After that pulse the request is cleared.
- R7: An in-event write that carries the value already held does not cause `cfg_commit_o`.
- R8: A write with `wr_in_event_i`=0 never causes `cfg_commit_o`, although it does update the held word.
- R9: A load through `ld_en_i` (same address map as the write port) sets the count or the held word and never causes `cfg_commit_o`. A load takes priority over a simultaneous write.
- R10: No `commit_o` is raised while `event_i` stays high or when it rises. A single event end raises exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 1 | High while an event is active; falling edge ends it |
| wr_en_i | input | 1 | Register write strobe |
| wr_in_event_i | input | 1 | Marks the write as made during an active event |
| wr_addr_i | input | $clog2(NUM_CFG+2) | 0 count low, 1 count MSB, 2+ configuration words |
| wr_data_i | input | DATA_W | Write data |
| ld_en_i | input | 1 | Power-up load strobe |
| ld_addr_i | input | $clog2(NUM_CFG+2) | Load address, same map as writes |
| ld_data_i | input | DATA_W | Load data |
| commit_o | output | 1 | One-cycle strobe at event end for time and count data |
| bank_o | output | 2 | Target bank for the commit (0..2) |
| cfg_commit_o | output | 1 | One-cycle strobe requesting commit of the configuration store |
| count_lo_o | output | CNT_W-1 | Count, low bits |
| count_msb_o | output | 1 | Count, MSB |

## Verification
The assertions assume that a counter write or load is never issued in the same cycle as an event end. They also assume that `event_i` is a clean level that changes only between clock edges. Under those assumptions the increment, hold and saturation properties describe every cycle. The stimulus drives every input at the falling clock edge. It always holds `event_i` high for at least one full cycle before dropping it, and it finishes each register access before the event end that follows. A reduced configuration (6-bit count, thresholds 10 and 20) lets the sweeps cover every count value, both bank boundaries and saturation.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int unsigned ADDR_CNT_LO   = 0;
  localparam int unsigned ADDR_CNT_HI   = 1;
  localparam int unsigned ADDR_CFG_BASE = 2;

  typedef enum logic [1:0] {
    BANK_LOW  = 2'd0,
    BANK_MID  = 2'd1,
    BANK_HIGH = 2'd2
  } bank_e;

  function automatic bank_e pick_bank(input int unsigned cnt,
                                      input int unsigned lim1,
                                      input int unsigned lim2);
    if (cnt >= lim2)      return BANK_HIGH;
    else if (cnt >= lim1) return BANK_MID;
    else                  return BANK_LOW;
  endfunction
endpackage

// File: rtl/evt_edge.sv
module evt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= event_i;
  end

  assign fall_o = prev_q & ~event_i;
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CNT_W  = 17,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned LO_W = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;
  logic             wr_any;

  assign at_max = &cnt_q;
  assign wr_any = wr_lo_i | wr_hi_i;

  // writes override the increment for that cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      if (wr_lo_i) cnt_q[LO_W-1:0] <= data_i[LO_W-1:0];
      if (wr_hi_i) cnt_q[CNT_W-1]  <= data_i[0];
    end else if (inc_i && !at_max) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_any && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r3_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_any && cnt_q == '1) |=> (cnt_q == '1));

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_any) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_cfg_track.sv
module evt_cfg_track #(
  parameter int unsigned NUM_CFG = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              mark_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flush_i,
  output logic              commit_o
);
  import evt_bank_pkg::*;

  logic [NUM_CFG-1:0] hit;
  logic [NUM_CFG-1:0] diff;
  logic               dirty_q;
  logic               commit_q;
  logic               dirty_set;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
    logic [DATA_W-1:0] shadow_q;

    assign hit[g]  = wr_i && (addr_i == ADDR_W'(ADDR_CFG_BASE + g));
    assign diff[g] = (data_i != shadow_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     shadow_q <= '0;
      else if (hit[g]) shadow_q <= data_i;
    end
  end

  assign dirty_set = mark_i && |(hit & diff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q  <= 1'b0;
      commit_q <= 1'b0;
    end else if (flush_i) begin
      commit_q <= dirty_q | dirty_set;
      dirty_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (dirty_set) dirty_q <= 1'b1;
    end
  end

  assign commit_o = commit_q;

  a_r8_unmarked_keeps_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !mark_i) |=> $stable(dirty_q));

  a_r6_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !dirty_q);
endmodule

// File: rtl/evt_bank_ctrl.sv
module evt_bank_ctrl #(
  parameter int unsigned CNT_W    = 17,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_CFG  = 8,
  parameter int unsigned BANK1_AT = 50000,
  parameter int unsigned BANK2_AT = 100000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          event_i,
  input  logic                          wr_en_i,
  input  logic                          wr_in_event_i,
  input  logic [$clog2(NUM_CFG+2)-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          ld_en_i,
  input  logic [$clog2(NUM_CFG+2)-1:0]  ld_addr_i,
  input  logic [DATA_W-1:0]             ld_data_i,
  output logic                          commit_o,
  output logic [1:0]                    bank_o,
  output logic                          cfg_commit_o,
  output logic [CNT_W-2:0]              count_lo_o,
  output logic                          count_msb_o
);
  import evt_bank_pkg::*;

  localparam int unsigned ADDR_W = $clog2(NUM_CFG + 2);

  logic              fall;
  logic              acc_en;
  logic              acc_mark;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_data;
  logic [CNT_W-1:0]  cnt;
  logic              commit_q;

  // load port wins over the write port; loads never mark for commit
  always_comb begin
    acc_en   = ld_en_i | wr_en_i;
    acc_addr = ld_en_i ? ld_addr_i : wr_addr_i;
    acc_data = ld_en_i ? ld_data_i : wr_data_i;
    acc_mark = wr_en_i & ~ld_en_i & wr_in_event_i;
  end

  evt_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_i),
    .fall_o  (fall)
  );

  evt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (fall),
    .wr_lo_i (acc_en && acc_addr == ADDR_W'(ADDR_CNT_LO)),
    .wr_hi_i (acc_en && acc_addr == ADDR_W'(ADDR_CNT_HI)),
    .data_i  (acc_data),
    .cnt_o   (cnt)
  );

  evt_cfg_track #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (acc_en),
    .mark_i   (acc_mark),
    .addr_i   (acc_addr),
    .data_i   (acc_data),
    .flush_i  (fall),
    .commit_o (cfg_commit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) commit_q <= 1'b0;
    else         commit_q <= fall;
  end

  assign commit_o    = commit_q;
  assign bank_o      = pick_bank(32'(cnt), BANK1_AT, BANK2_AT);
  assign count_lo_o  = cnt[CNT_W-2:0];
  assign count_msb_o = cnt[CNT_W-1];

  a_r10_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  a_r10_no_commit_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && $past(event_i)) |=> !commit_o);

  a_r6_cfg_with_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_commit_o |-> commit_o);

  a_r4_bank_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_o != 2'd3);
endmodule

// File: tb/evt_bank_ctrl_bench.sv
module evt_bank_ctrl_bench;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned DW    = 16;
  localparam int unsigned NCFG  = 2;
  localparam int unsigned B1    = 10;
  localparam int unsigned B2    = 20;
  localparam int unsigned AW    = $clog2(NCFG + 2);
  localparam int unsigned MAXC  = (1 << CNT_W) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          event_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_in_event_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          ld_en_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [DW-1:0] ld_data_i = '0;
  logic          commit_o;
  logic [1:0]    bank_o;
  logic          cfg_commit_o;
  logic [CNT_W-2:0] count_lo_o;
  logic          count_msb_o;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #2 clk_i = ~clk_i;

  evt_bank_ctrl #(.CNT_W(CNT_W), .DATA_W(DW), .NUM_CFG(NCFG),
                  .BANK1_AT(B1), .BANK2_AT(B2)) u_evt_bank_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .event_i(event_i),
    .wr_en_i(wr_en_i), .wr_in_event_i(wr_in_event_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .commit_o(commit_o), .bank_o(bank_o), .cfg_commit_o(cfg_commit_o),
    .count_lo_o(count_lo_o), .count_msb_o(count_msb_o)
  );

  function automatic int exp_bank(input int c);
    return (c >= B2) ? 2 : (c >= B1) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int count_now();
    return int'({count_msb_o, count_lo_o});
  endfunction

  // one event of two high cycles with an optional write inside it
  task automatic run_event(input bit do_wr, input int addr, input int data,
                           input bit flag, input int exp_cfg, input string req);
    @(negedge clk_i) event_i = 1'b1;
    if (do_wr) begin
      wr_en_i = 1'b1; wr_addr_i = AW'(addr); wr_data_i = DW'(data);
      wr_in_event_i = flag;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_in_event_i = 1'b0;
    check("R10 no commit while high", int'(commit_o), 0);
    @(negedge clk_i) event_i = 1'b0;
    @(posedge clk_i); #1;
    exp_cnt = (exp_cnt < MAXC) ? exp_cnt + 1 : MAXC;
    check("R2 commit at event end", int'(commit_o), 1);
    check((exp_cnt == MAXC) ? "R3 saturated count" : "R2 count", count_now(), exp_cnt);
    check("R4 bank", int'(bank_o), exp_bank(exp_cnt));
    check(req, int'(cfg_commit_o), exp_cfg);
    @(posedge clk_i); #1;
    check("R10 single pulse", int'(commit_o), 0);
  endtask

  task automatic reg_write(input int addr, input int data, input bit flag);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = AW'(addr); wr_data_i = DW'(data); wr_in_event_i = flag;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_in_event_i = 1'b0;
  endtask

  task automatic set_count(input int v);
    reg_write(0, v & ((1 << (CNT_W - 1)) - 1), 1'b0);
    reg_write(1, (v >> (CNT_W - 1)) & 1, 1'b0);
    exp_cnt = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 count", count_now(), 0);
    check("R1 commit", int'(commit_o), 0);
    check("R1 cfg_commit", int'(cfg_commit_o), 0);
    check("R1 bank", int'(bank_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R10: a rising edge and a long high phase raise no commit
    @(negedge clk_i) event_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk_i); #1;
      check("R10 held high", int'(commit_o), 0);
    end
    @(negedge clk_i) event_i = 1'b0;
    @(posedge clk_i); #1;
    exp_cnt = 1;
    check("R2 long event commit", int'(commit_o), 1);
    check("R2 long event count", count_now(), 1);

    // R2/R3/R4: sweep through both thresholds into saturation
    for (int n = 0; n < MAXC + 4; n++)
      run_event(1'b0, 0, 0, 1'b0, 0, "R6 no cfg commit without write");

    // R5: every writable count, then one event
    for (int v = 0; v <= MAXC; v++) begin
      set_count(v);
      check("R5 written count", count_now(), v);
      check("R5 bank after write", int'(bank_o), exp_bank(v));
      run_event(1'b0, 0, 0, 1'b0, 0, "R6 idle cfg");
    end
    set_count(B1 + 5);
    set_count(0);
    check("R5 cleared to bank 0", int'(bank_o), 0);

    // R6/R7/R8 on the configuration words
    run_event(1'b1, 2, 16'h00A5, 1'b1, 1, "R6 changed in-event write");
    run_event(1'b0, 0, 0, 1'b0, 0, "R6 request cleared");
    run_event(1'b1, 2, 16'h00A5, 1'b1, 0, "R7 same value write");
    run_event(1'b1, 3, 16'h1234, 1'b0, 0, "R8 unflagged write");
    run_event(1'b1, 3, 16'h1234, 1'b1, 0, "R8 unflagged write updated word");
    run_event(1'b1, 3, 16'h4321, 1'b1, 1, "R6 second word");
    reg_write(2, 16'h0077, 1'b1);
    run_event(1'b0, 0, 0, 1'b0, 1, "R6 write before event end");

    // R9: load port
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_addr_i = AW'(2); ld_data_i = 16'h0BEE;
    wr_en_i = 1'b1; wr_addr_i = AW'(3); wr_data_i = 16'h0001; wr_in_event_i = 1'b1;
    @(negedge clk_i);
    ld_en_i = 1'b0; wr_en_i = 1'b0; wr_in_event_i = 1'b0;
    run_event(1'b0, 0, 0, 1'b0, 0, "R9 load not committed");
    run_event(1'b1, 2, 16'h0BEE, 1'b1, 0, "R9 loaded word held");
    run_event(1'b1, 3, 16'h4321, 1'b1, 0, "R9 load wins over write");
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_addr_i = AW'(0); ld_data_i = 16'd7;
    @(negedge clk_i);
    ld_addr_i = AW'(1); ld_data_i = 16'd1;
    @(negedge clk_i);
    ld_en_i = 1'b0;
    exp_cnt = 7 + (1 << (CNT_W - 1));
    check("R9 loaded count", count_now(), exp_cnt);
    run_event(1'b0, 0, 0, 1'b0, 0, "R9 no cfg after count load");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule